// File: doc/BRIEF.md
# Edge-Triggered Line Interrupt Controller

This block watches a 32-position vector of input lines, of which positions 0 to 19 and 29 are populated. Every populated line passes through a two-flop synchroniser and an edge detector. Each line can be set to react to its rising edge, its falling edge, or both. A reacted edge latches a per-line pending flag. The interrupt request for a line is its pending flag gated by its interrupt enable. A separate event output gives a one-cycle pulse for each reacted edge on lines whose event enable is set, whether or not that line is already pending.

Software controls the block through a word-wide synchronous register bus with an address, write data, a write strobe and combinational read data. Software can also raise a pending flag by writing a trigger bit. That trigger bit stays set until the pending flag is acknowledged.

The nine lowest lines do not come from fixed pins. A port-select map picks, for each of them, the same-numbered pin of GPIO port A, B or F. Lines 0 to 4 have 2-bit selectors and lines 5 to 8 have 1-bit selectors. Lines 9 and up come straight from an auxiliary input vector.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, except the interrupt-enable register, which reads 0x200E0000 (lines 17, 18, 19 and 29 enabled). The `irq_o` and `evt_o` outputs are zero.
- R2: Only bit positions 0 to 19 and 29 are stored in the interrupt-enable, event-enable, rise-enable, fall-enable, software-trigger and pending registers. All other positions ignore writes and read 0.
- R3: A rising edge on a line whose rise-enable bit is set sets its pending bit. The bit becomes visible on the third rising clock edge after the input changes (two synchroniser flops plus the history flop).
- R4: A falling edge sets pending when the fall-enable bit is set. With both enables set, either edge sets pending. An edge whose enable is clear has no effect.
- R5: The pending register is write-1-to-clear. Writing 1 clears a bit and writing 0 has no effect. A trigger in the same cycle as a clear of that bit wins, and the bit stays set.
- R6: `irq_o[i]` is high exactly when pending bit i and interrupt-enable bit i are both set. Pending bits latch regardless of the interrupt enable.
- R7: `evt_o[i]` pulses for one cycle, at the same time pending would be set, for each enabled edge on a line whose event-enable bit is set. This happens regardless of the line's pending state.
- R8: Writing 1 to a software-trigger bit that reads 0 sets that bit. If the line's interrupt enable is set, the write also sets the pending bit on the next clock. Writing 1 to a trigger bit that already reads 1 does nothing. A trigger bit clears only when its pending bit is acknowledged with a write of 1.
- R9: An edge detected in the cycle in which the rise-enable or fall-enable register is written does not set any pending bit.
- R10: Selector code 0 picks port A, 1 picks port B and 2 picks port F. Code 3 drives the line low. Lines 0 to 3 have 2-bit fields at bit offsets 0, 8, 16 and 24 of select register 0. Line 4 has a 2-bit field at offset 0 of select register 1.
- R11: Lines 5, 6 and 7 have 1-bit fields at offsets 8, 16 and 24 of select register 1, and line 8 has a 1-bit field at offset 0 of select register 2, so they can pick only port A or B. All other bits of the select registers read 0.
- R12: Register word addresses are fixed as follows:
  - 0: interrupt enable
  - 1: event enable
  - 2: rise enable
  - 3: fall enable
  - 4: software trigger
  - 5: pending
  - 6 to 8: select registers 0 to 2
  - all other addresses read 0.

  Lines 9 to 31 take `aux_in[i-9]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| port_a | input | 9 | GPIO port A pins 0 to 8 |
| port_b | input | 9 | GPIO port B pins 0 to 8 |
| port_f | input | 9 | GPIO port F pins 0 to 8 |
| aux_in | input | 23 | Direct inputs for lines 9 to 31 |
| irq_o | output | 32 | Per-line interrupt request |
| evt_o | output | 32 | Per-line one-cycle event pulse |

## Verification
The bench builds the block with its default parameters: 32 line positions, 9 multiplexed lines of which 5 have wide selectors, and 4 selector fields per select register. These defaults put both selector widths, the spill of line 8 into a third select register, and the unpopulated positions 20 to 28, 30 and 31 within reach of every randomized pass. Random passes draw pin values, select-register contents (including code 3) and enable masks, and compare pending, `irq_o` and `evt_o` against a model of edge polarity. Directed cases cover the software trigger sequence, the edge that coincides with a rise-enable write, and event pulses on lines that are already pending.

// File: rtl/eic_pkg.sv
`timescale 1ns/1ps
package eic_pkg;
    localparam int LINE_N         = 32;
    localparam int MUX_N          = 9;
    localparam int WIDE_N         = 5;
    localparam int FIELDS_PER_REG = 4;
    localparam int FIELD_STRIDE   = 8;
    localparam int SEL_REGS       = (MUX_N + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
    localparam int ADDR_W         = 4;
    localparam int SEL_BASE       = 6;
    localparam int AUX_N          = LINE_N - MUX_N;

    localparam logic [LINE_N-1:0] LINE_IMPL  = 32'h200F_FFFF;
    localparam logic [LINE_N-1:0] IRQ_EN_RST = 32'h200E_0000;

    typedef enum logic [ADDR_W-1:0] {
        A_IRQ_EN  = 4'd0,
        A_EVT_EN  = 4'd1,
        A_RISE_EN = 4'd2,
        A_FALL_EN = 4'd3,
        A_SW_TRIG = 4'd4,
        A_PENDING = 4'd5
    } reg_addr_e;

    typedef logic [1:0] port_code_t;
    localparam port_code_t PORT_A = 2'd0;
    localparam port_code_t PORT_B = 2'd1;
    localparam port_code_t PORT_F = 2'd2;

    typedef struct packed {
        logic [LINE_N-1:0] irq_en;
        logic [LINE_N-1:0] evt_en;
        logic [LINE_N-1:0] rise_en;
        logic [LINE_N-1:0] fall_en;
        logic [LINE_N-1:0] sw_trig;
        logic [LINE_N-1:0] pending;
        logic [LINE_N-1:0] evt;
        logic [SEL_REGS-1:0][LINE_N-1:0] sel;
    } ctl_state_t;

    // Writable bits of select register r: bit 0 of every field, bit 1 for wide fields.
    function automatic logic [LINE_N-1:0] sel_wmask(input int r);
        logic [LINE_N-1:0] m;
        m = '0;
        for (int i = 0; i < MUX_N; i++) begin
            if (i / FIELDS_PER_REG == r) begin
                m[FIELD_STRIDE * (i % FIELDS_PER_REG)] = 1'b1;
                if (i < WIDE_N) m[FIELD_STRIDE * (i % FIELDS_PER_REG) + 1] = 1'b1;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/eic_port_mux.sv
`timescale 1ns/1ps
module eic_port_mux #(
    parameter int N = 9
) (
    input  logic [N-1:0]   port_a,
    input  logic [N-1:0]   port_b,
    input  logic [N-1:0]   port_f,
    input  logic [2*N-1:0] sel_code,
    output logic [N-1:0]   line_out
);
    import eic_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_line
        always_comb begin
            case (port_code_t'(sel_code[2*i +: 2]))
                PORT_A:  line_out[i] = port_a[i];
                PORT_B:  line_out[i] = port_b[i];
                PORT_F:  line_out[i] = port_f[i];
                default: line_out[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/eic_edge_det.sv
`timescale 1ns/1ps
module eic_edge_det #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = raw_in;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.prev;
    assign fall_o = ~sync_q.s2 & sync_q.prev;

    // R3: a detected rising edge is followed by a high history bit
    p_rise_hist_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((sync_q.prev & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/eic_regfile.sv
`timescale 1ns/1ps
module eic_regfile
    import eic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [LINE_N-1:0]   bus_wdata,
    input  logic                bus_we,
    output logic [LINE_N-1:0]   bus_rdata,
    input  logic [LINE_N-1:0]   rise_det,
    input  logic [LINE_N-1:0]   fall_det,
    output logic [2*MUX_N-1:0]  sel_code,
    output logic [LINE_N-1:0]   irq_o,
    output logic [LINE_N-1:0]   evt_o
);
    ctl_state_t st_d, st_q;

    logic              wr_irq, wr_evt, wr_rise, wr_fall, wr_swt, wr_pend;
    logic [LINE_N-1:0] trig, hw_set, sw_new, sw_set, clr;

    always_comb begin
        wr_irq  = bus_we && (bus_addr == A_IRQ_EN);
        wr_evt  = bus_we && (bus_addr == A_EVT_EN);
        wr_rise = bus_we && (bus_addr == A_RISE_EN);
        wr_fall = bus_we && (bus_addr == A_FALL_EN);
        wr_swt  = bus_we && (bus_addr == A_SW_TRIG);
        wr_pend = bus_we && (bus_addr == A_PENDING);

        trig   = ((rise_det & st_q.rise_en) | (fall_det & st_q.fall_en)) & LINE_IMPL;
        hw_set = (wr_rise || wr_fall) ? '0 : trig;
        sw_new = wr_swt ? (bus_wdata & ~st_q.sw_trig & LINE_IMPL) : '0;
        sw_set = sw_new & st_q.irq_en;
        clr    = wr_pend ? (bus_wdata & LINE_IMPL) : '0;

        st_d = st_q;
        if (wr_irq)  st_d.irq_en  = bus_wdata & LINE_IMPL;
        if (wr_evt)  st_d.evt_en  = bus_wdata & LINE_IMPL;
        if (wr_rise) st_d.rise_en = bus_wdata & LINE_IMPL;
        if (wr_fall) st_d.fall_en = bus_wdata & LINE_IMPL;
        st_d.sw_trig = (st_q.sw_trig & ~clr) | sw_new;
        st_d.pending = (st_q.pending & ~clr) | hw_set | sw_set;
        st_d.evt     = trig & st_q.evt_en;
        for (int r = 0; r < SEL_REGS; r++) begin
            if (bus_we && (bus_addr == ADDR_W'(SEL_BASE + r)))
                st_d.sel[r] = bus_wdata & sel_wmask(r);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.irq_en <= IRQ_EN_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_IRQ_EN:  bus_rdata = st_q.irq_en;
            A_EVT_EN:  bus_rdata = st_q.evt_en;
            A_RISE_EN: bus_rdata = st_q.rise_en;
            A_FALL_EN: bus_rdata = st_q.fall_en;
            A_SW_TRIG: bus_rdata = st_q.sw_trig;
            A_PENDING: bus_rdata = st_q.pending;
            default: begin
                for (int r = 0; r < SEL_REGS; r++) begin
                    if (bus_addr == ADDR_W'(SEL_BASE + r)) bus_rdata = st_q.sel[r];
                end
            end
        endcase
    end

    for (genvar i = 0; i < MUX_N; i++) begin : g_code
        localparam int R   = i / FIELDS_PER_REG;
        localparam int OFF = FIELD_STRIDE * (i % FIELDS_PER_REG);
        assign sel_code[2*i +: 2] = st_q.sel[R][OFF +: 2];
    end

    assign irq_o = st_q.pending & st_q.irq_en;
    assign evt_o = st_q.evt;

    // R2: unpopulated positions never hold state
    p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.irq_en | st_q.evt_en | st_q.rise_en | st_q.fall_en
          | st_q.sw_trig | st_q.pending) & ~LINE_IMPL) == '0);

    // R5: acknowledged bits are clear afterwards unless re-triggered that cycle
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((st_q.pending & $past(bus_wdata) & LINE_IMPL
                      & ~$past(hw_set | sw_set)) == '0));

    // R5: with no acknowledge and no trigger, pending holds
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pend && (hw_set | sw_set) == '0) |=> $stable(st_q.pending));

    // R9: a trigger-enable write lets no new pending bit appear
    p_drop_on_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise || wr_fall) |=> ((st_q.pending & ~$past(st_q.pending)) == '0));

    // R8: acknowledging pending also clears the software-trigger bit
    p_swt_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((st_q.sw_trig & $past(bus_wdata)) == '0));
endmodule

// File: rtl/edge_irq_ctrl.sv
`timescale 1ns/1ps
module edge_irq_ctrl
    import eic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [LINE_N-1:0]   bus_wdata,
    input  logic                bus_we,
    output logic [LINE_N-1:0]   bus_rdata,
    input  logic [MUX_N-1:0]    port_a,
    input  logic [MUX_N-1:0]    port_b,
    input  logic [MUX_N-1:0]    port_f,
    input  logic [AUX_N-1:0]    aux_in,
    output logic [LINE_N-1:0]   irq_o,
    output logic [LINE_N-1:0]   evt_o
);
    logic [2*MUX_N-1:0] sel_code;
    logic [MUX_N-1:0]   mux_line;
    logic [LINE_N-1:0]  line_raw, rise_det, fall_det;

    eic_port_mux #(.N(MUX_N)) u_mux (
        .port_a   (port_a),
        .port_b   (port_b),
        .port_f   (port_f),
        .sel_code (sel_code),
        .line_out (mux_line)
    );

    assign line_raw = {aux_in, mux_line};

    eic_edge_det #(.W(LINE_N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (line_raw),
        .rise_o (rise_det),
        .fall_o (fall_det)
    );

    eic_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .rise_det  (rise_det),
        .fall_det  (fall_det),
        .sel_code  (sel_code),
        .irq_o     (irq_o),
        .evt_o     (evt_o)
    );
endmodule

// File: tb/sim_edge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_edge_irq_ctrl;
    localparam logic [31:0] IMPL = 32'h200F_FFFF;
    localparam logic [3:0]  AD_IRQ = 4'd0, AD_EVT = 4'd1, AD_RISE = 4'd2, AD_FALL = 4'd3,
                            AD_SWT = 4'd4, AD_PEND = 4'd5, AD_SEL0 = 4'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata, irq, evt;
    logic [8:0]  pa = '0, pb = '0, pf = '0;
    logic [22:0] aux = '0;
    int          n_vec = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    edge_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
        .bus_rdata(rdata), .port_a(pa), .port_b(pb), .port_f(pf), .aux_in(aux),
        .irq_o(irq), .evt_o(evt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Writable select bits per R10/R11 field layout
    function automatic logic [31:0] exp_sel_mask(input int r);
        logic [31:0] m;
        m = '0;
        if (r == 0) m = 32'h0303_0303;
        if (r == 1) m = 32'h0101_0103;
        if (r == 2) m = 32'h0000_0001;
        return m;
    endfunction

    function automatic logic [31:0] exp_lines(input logic [8:0] a, input logic [8:0] b,
                                              input logic [8:0] f, input logic [22:0] x,
                                              input logic [2:0][31:0] s);
        logic [31:0] v;
        v = {x, 9'd0};
        for (int i = 0; i < 9; i++) begin
            logic [1:0] c;
            c = 2'((s[i/4] >> (8*(i%4))) & ((i < 5) ? 32'd3 : 32'd1));
            case (c)
                2'd0: v[i] = a[i];
                2'd1: v[i] = b[i];
                2'd2: v[i] = f[i];
                default: v[i] = 1'b0;
            endcase
        end
        return v;
    endfunction

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seed;
        seed = $urandom(32'd4711);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values, R12 address map
        rd(AD_IRQ, v);  chk("R1 irq_en reset", v, 32'h200E_0000);
        rd(AD_EVT, v);  chk("R1 evt_en reset", v, 32'h0);
        rd(AD_PEND, v); chk("R1 pending reset", v, 32'h0);
        rd(AD_SEL0, v); chk("R1 sel0 reset", v, 32'h0);
        rd(4'd12, v);   chk("R12 unused address", v, 32'h0);
        chk("R1 irq_o reset", irq, 32'h0);
        chk("R1 evt_o reset", evt, 32'h0);

        // R2 unpopulated bits
        wr(AD_EVT, 32'hFFFF_FFFF);
        rd(AD_EVT, v); chk("R2 evt_en mask", v, IMPL);
        wr(AD_EVT, 32'h0);

        // R11 select field layout
        wr(AD_SEL0 + 4'd1, 32'hFFFF_FFFF);
        rd(AD_SEL0 + 4'd1, v); chk("R11 sel1 fields", v, 32'h0101_0103);
        wr(AD_SEL0 + 4'd2, 32'hFFFF_FFFF);
        rd(AD_SEL0 + 4'd2, v); chk("R11 sel2 fields", v, 32'h0000_0001);
        wr(AD_SEL0 + 4'd1, 32'h0);
        wr(AD_SEL0 + 4'd2, 32'h0);

        // R8 software trigger sequence, R5 write-zero
        wr(AD_IRQ, 32'h0000_0008);
        wr(AD_SWT, 32'h0000_0008);
        rd(AD_PEND, v); chk("R8 swt sets pending", v, 32'h8);
        rd(AD_SWT, v);  chk("R8 swt bit held", v, 32'h8);
        chk("R6 irq_o from swt", irq, 32'h8);
        wr(AD_PEND, 32'h0000_0008);
        rd(AD_SWT, v);  chk("R8 swt cleared by ack", v, 32'h0);
        wr(AD_SWT, 32'h0000_0010);
        rd(AD_PEND, v); chk("R8 masked swt no pending", v, 32'h0);
        wr(AD_IRQ, 32'h0000_0018);
        wr(AD_SWT, 32'h0000_0010);
        rd(AD_PEND, v); chk("R8 swt already set no effect", v, 32'h0);
        wr(AD_PEND, 32'h0);
        rd(AD_SWT, v);  chk("R5 write zero keeps swt", v, 32'h10);
        wr(AD_PEND, 32'h0000_0010);
        wr(AD_SWT, 32'h0000_0010);
        rd(AD_PEND, v); chk("R8 swt after ack", v, 32'h10);
        wr(AD_PEND, 32'h0);
        rd(AD_PEND, v); chk("R5 write zero no clear", v, 32'h10);
        wr(AD_PEND, 32'hFFFF_FFFF);
        rd(AD_PEND, v); chk("R5 clear", v, 32'h0);

        // R4/R7 both edges on line 12 (aux bit 3)
        wr(AD_RISE, 32'h0000_1000);
        wr(AD_FALL, 32'h0000_1000);
        wr(AD_EVT,  32'h0000_1000);
        aux[3] = 1'b1;
        repeat (3) @(negedge clk);
        rd(AD_PEND, v); chk("R3 rising sets pending", v, 32'h1000);
        chk("R7 event pulse", evt, 32'h1000);
        @(negedge clk);
        chk("R7 pulse one cycle", evt, 32'h0);
        aux[3] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 event while pending", evt, 32'h1000);
        rd(AD_PEND, v); chk("R4 falling keeps pending", v, 32'h1000);
        wr(AD_PEND, 32'hFFFF_FFFF);
        wr(AD_FALL, 32'h0);
        aux[3] = 1'b1;
        repeat (3) @(negedge clk);
        wr(AD_PEND, 32'hFFFF_FFFF);
        aux[3] = 1'b0;
        repeat (3) @(negedge clk);
        rd(AD_PEND, v); chk("R4 falling disabled", v, 32'h0);

        // R9 edge coinciding with rise-enable write (line 10, aux bit 1)
        wr(AD_RISE, 32'h0000_0400);
        aux[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = AD_RISE; wdata = 32'h0000_0400; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        rd(AD_PEND, v); chk("R9 edge dropped on cfg write", v, 32'h0);
        aux[1] = 1'b0;
        repeat (4) @(negedge clk);
        wr(AD_PEND, 32'hFFFF_FFFF);

        // Random passes: R3 R4 R6 R7 R10 R11 R12
        for (int it = 0; it < 60; it++) begin
            logic [2:0][31:0] s;
            logic [31:0] re, fe, ie, ee, old_l, new_l, tr;
            logic [8:0]  na, nb, nf;
            logic [22:0] nx;
            for (int r = 0; r < 3; r++) begin
                s[r] = $urandom;
                wr(AD_SEL0 + 4'(r), s[r]);
                rd(AD_SEL0 + 4'(r), v);
                chk("R10 select readback", v, s[r] & exp_sel_mask(r));
                s[r] = s[r] & exp_sel_mask(r);
            end
            re = $urandom; fe = $urandom; ie = $urandom; ee = $urandom;
            wr(AD_RISE, re); wr(AD_FALL, fe); wr(AD_IRQ, ie); wr(AD_EVT, ee);
            re &= IMPL; fe &= IMPL; ie &= IMPL; ee &= IMPL;
            wr(AD_PEND, 32'hFFFF_FFFF);
            old_l = exp_lines(pa, pb, pf, aux, s);
            na = 9'($urandom); nb = 9'($urandom); nf = 9'($urandom); nx = 23'($urandom);
            pa = na; pb = nb; pf = nf; aux = nx;
            new_l = exp_lines(na, nb, nf, nx, s);
            tr = ((new_l & ~old_l & re) | (~new_l & old_l & fe)) & IMPL;
            repeat (3) @(negedge clk);
            rd(AD_PEND, v); chk("R3/R4 random pending", v, tr);
            chk("R6 random irq_o", irq, tr & ie);
            chk("R7 random evt_o", evt, tr & ee);
            @(negedge clk);
            chk("R7 random evt_o ends", evt, 32'h0);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule